// File: doc/BRIEF.md
# Compact Registered ALU with Condition Flags

This block is the arithmetic/logic stage of a small RISC processing element. Its operation set is kept small on purpose, so that each result bit costs one lookup element plus the carry chain. It takes two operands `a` and `b` and a bypass operand `c`. Every enabled clock edge loads a result register and four condition flags: carry, signed overflow, operand equality and zero of `a`.

A two-bit mode input picks the behaviour. The general ALU mode gives add, subtract, AND and XOR under two select bits. There is no OR, so software builds OR from the remaining operations. The add-or-pass mode chooses between `a + b` and the bypass operand `c`. The accumulate mode either adds `a` to the current result or loads `b` into the result register. The equality flag is built from two-bit compare slices and the zero flag from four-bit groups, so the width must be a multiple of four.

Top module: `compact_alu`

## Requirements
- R1: A synchronous active-high `rst` clears `q`, `cy`, `ov`, `eq_ab` and `zero_a` at the next rising edge, whatever the value of `en`.
- R2: While `en` is low and `rst` is low, every output keeps its value at each rising edge, whatever the other inputs do.
- R3: With `mode` = 2'b00, `s1`=1 loads `q` with `a + b` when `s2`=1 and with `a - b` when `s2`=0, both modulo 2^W.
- R4: With `mode` = 2'b00 and `s1`=0, `q` takes `a & b` when `s2`=1 and `a ^ b` when `s2`=0, and `cy` and `ov` are loaded with 0.
- R5: For an addition `cy` is the carry out of bit W-1. For a subtraction `cy` is 1 exactly when `a >= b` as unsigned numbers, meaning no borrow.
- R6: For an addition or subtraction `ov` is 1 exactly when the true result of the operands, read as two's-complement numbers, does not fit in W signed bits.
- R7: With `mode` = 2'b01, `add_sel`=1 loads `a + b` with carry and overflow as in R5/R6, and `add_sel`=0 loads `c` with `cy` = `ov` = 0.
- R8: With `mode` = 2'b10, `add_sel`=1 loads `q + a` (the old `q`), with carry and overflow as for an addition, and `add_sel`=0 loads `b` with `cy` = `ov` = 0.
- R9: `eq_ab` is loaded with 1 exactly when `a == b`, in every mode.
- R10: `zero_a` is loaded with 1 exactly when `a` is all zeros, in every mode.
- R11: `mode` = 2'b11 behaves exactly as `mode` = 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Clock enable for all registers |
| mode | input | 2 | 00/11 ALU, 01 add-or-pass, 10 accumulate-or-load |
| s1 | input | 1 | ALU select: 1 arithmetic, 0 logic |
| s2 | input | 1 | ALU select: add/AND when 1, subtract/XOR when 0 |
| add_sel | input | 1 | Add control for the add-or-pass and accumulate modes |
| a | input | W | Operand A |
| b | input | W | Operand B |
| c | input | W | Bypass operand |
| q | output | W | Registered result |
| cy | output | 1 | Registered carry (no-borrow on subtract) |
| ov | output | 1 | Registered signed overflow |
| eq_ab | output | 1 | Registered A equals B flag |
| zero_a | output | 1 | Registered A is zero flag |

## Verification
The bench builds the block with W = 4. At that width every pair of operands fits in a full sweep, for all four ALU operations in both ALU mode encodings and for both choices of the add-or-pass mode. Every carry, borrow and signed overflow boundary is therefore reached, along with the most negative value, all-ones, zero and equal operands. Accumulate chains are run from every load value, so that wrap-around of the result register and carries out of it are also reached.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    MODE_ALU     = 2'b00,
    MODE_ADDPASS = 2'b01,
    MODE_ACCUM   = 2'b10,
    MODE_ALU_ALT = 2'b11
  } alu_mode_e;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         ovf
);
  function automatic logic [W:0] chain_add(logic [W-1:0] p, logic [W-1:0] r, logic cin);
    return {1'b0, p} + {1'b0, r} + {{W{1'b0}}, cin};
  endfunction

  function automatic logic sign_ovf(logic xs, logic ys, logic rs);
    return (xs == ys) && (rs != xs);
  endfunction

  logic [W-1:0] y_eff;
  logic [W:0]   total;

  assign y_eff = sub ? ~y : y;
  assign total = chain_add(x, y_eff, sub);
  assign sum   = total[W-1:0];
  assign cout  = total[W];
  assign ovf   = sign_ovf(x[W-1], y_eff[W-1], total[W-1]);
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         and_sel,
  output logic [W-1:0] y
);
  assign y = and_sel ? (a & b) : (a ^ b);
endmodule

// File: rtl/alu_cmp.sv
module alu_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         same,
  output logic         zero
);
  localparam int NPAIR = W / 2;
  localparam int NNIB  = W / 4;

  logic [NPAIR-1:0] pair_eq;
  logic [NNIB-1:0]  nib_zero;

  for (genvar i = 0; i < NPAIR; i++) begin : g_pair
    assign pair_eq[i] = (a[2*i+1:2*i] == b[2*i+1:2*i]);
  end

  for (genvar g = 0; g < NNIB; g++) begin : g_nib
    assign nib_zero[g] = (a[4*g+3:4*g] == 4'd0);
  end

  assign same = &pair_eq;
  assign zero = &nib_zero;

  initial begin
    a_width_mult4 : assert (W % 4 == 0 && W >= 4)
      else $error("width must be a positive multiple of 4");
  end
endmodule

// File: rtl/compact_alu.sv
module compact_alu
  import alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [1:0]   mode,
  input  logic         s1,
  input  logic         s2,
  input  logic         add_sel,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] q,
  output logic         cy,
  output logic         ov,
  output logic         eq_ab,
  output logic         zero_a
);
  alu_mode_e    m;
  logic         is_alu, is_accum, arith_path, do_sub;
  logic [W-1:0] add_x, add_y, sum, logic_y, q_next;
  logic         cout, ovf, same, zero;
  logic [W-1:0] q_r;
  logic         cy_r, ov_r, eq_r, zr_r;

  assign m          = alu_mode_e'(mode);
  assign is_alu     = (m == MODE_ALU) || (m == MODE_ALU_ALT);
  assign is_accum   = (m == MODE_ACCUM);
  assign do_sub     = is_alu && !s2;
  assign arith_path = is_alu ? s1 : add_sel;
  assign add_x      = is_accum ? q_r : a;
  assign add_y      = is_accum ? a : b;

  alu_addsub #(.W(W)) u_addsub (
    .x(add_x), .y(add_y), .sub(do_sub), .sum(sum), .cout(cout), .ovf(ovf)
  );

  alu_logic #(.W(W)) u_logic (
    .a(a), .b(b), .and_sel(s2), .y(logic_y)
  );

  alu_cmp #(.W(W)) u_cmp (
    .a(a), .b(b), .same(same), .zero(zero)
  );

  always_comb begin
    if (arith_path)    q_next = sum;
    else if (is_alu)   q_next = logic_y;
    else if (is_accum) q_next = b;
    else               q_next = c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r  <= '0;
      cy_r <= 1'b0;
      ov_r <= 1'b0;
      eq_r <= 1'b0;
      zr_r <= 1'b0;
    end else if (en) begin
      q_r  <= q_next;
      cy_r <= arith_path & cout;
      ov_r <= arith_path & ovf;
      eq_r <= same;
      zr_r <= zero;
    end
  end

  assign q      = q_r;
  assign cy     = cy_r;
  assign ov     = ov_r;
  assign eq_ab  = eq_r;
  assign zero_a = zr_r;

  logic past_valid = 1'b0;
  always_ff @(posedge clk) past_valid <= 1'b1;

  a_r1_reset_clears : assert property (@(posedge clk)
    past_valid && $past(rst) |-> (q == '0) && !cy && !ov && !eq_ab && !zero_a);

  a_r2_hold : assert property (@(posedge clk) disable iff (rst)
    past_valid && !$past(rst) && !$past(en)
      |-> $stable(q) && $stable(cy) && $stable(ov) && $stable(eq_ab) && $stable(zero_a));

  a_r4_logic_no_flags : assert property (@(posedge clk) disable iff (rst)
    past_valid && $past(en && !rst && is_alu && !s1) |-> !cy && !ov);

  a_r7_pass_c : assert property (@(posedge clk) disable iff (rst)
    past_valid && $past(en && !rst && m == MODE_ADDPASS && !add_sel)
      |-> (q == $past(c)) && !cy && !ov);

  a_r8_load_b : assert property (@(posedge clk) disable iff (rst)
    past_valid && $past(en && !rst && is_accum && !add_sel)
      |-> (q == $past(b)) && !cy && !ov);

  a_r9_equal : assert property (@(posedge clk) disable iff (rst)
    past_valid && $past(en && !rst) |-> eq_ab == ($past(a) == $past(b)));

  a_r10_zero : assert property (@(posedge clk) disable iff (rst)
    past_valid && $past(en && !rst) |-> zero_a == ($past(a) == '0));
endmodule

// File: tb/test_compact_alu.sv
module test_compact_alu;
  localparam int TW   = 4;
  localparam int FULL = 1 << TW;
  localparam int HALF = 1 << (TW - 1);

  logic          clk = 1'b0;
  logic          rst, en, s1, s2, add_sel;
  logic [1:0]    mode;
  logic [TW-1:0] a, b, c;
  logic [TW-1:0] q;
  logic          cy, ov, eq_ab, zero_a;
  int            nchk = 0;
  int            nfail = 0;

  always #2.5 clk = ~clk;

  compact_alu #(.W(TW)) i_compact_alu (
    .clk(clk), .rst(rst), .en(en), .mode(mode), .s1(s1), .s2(s2),
    .add_sel(add_sel), .a(a), .b(b), .c(c),
    .q(q), .cy(cy), .ov(ov), .eq_ab(eq_ab), .zero_a(zero_a)
  );

  // integer reference: returns {ov, cy, result}
  function automatic logic [TW+1:0] ref_arith(int x, int y, bit sub);
    int r, sx, sy, sr;
    bit rc, ro;
    r  = sub ? x - y : x + y;
    rc = sub ? (x >= y) : (r >= FULL);
    sx = (x >= HALF) ? x - FULL : x;
    sy = (y >= HALF) ? y - FULL : y;
    sr = sub ? sx - sy : sx + sy;
    ro = (sr > HALF - 1) || (sr < -HALF);
    r  = ((r % FULL) + FULL) % FULL;
    return {ro, rc, r[TW-1:0]};
  endfunction

  task automatic check(string req, logic [TW-1:0] eq_q, logic ecy, logic eov,
                       logic eeq, logic ezr);
    nchk++;
    if (q !== eq_q || cy !== ecy || ov !== eov || eq_ab !== eeq || zero_a !== ezr) begin
      nfail++;
      $display("FAIL %s: got q=%h cy=%b ov=%b eq=%b z=%b, expected q=%h cy=%b ov=%b eq=%b z=%b",
               req, q, cy, ov, eq_ab, zero_a, eq_q, ecy, eov, eeq, ezr);
    end
  endtask

  task automatic drive(logic [1:0] md, logic p1, logic p2, logic ad,
                       logic [TW-1:0] va, logic [TW-1:0] vb, logic [TW-1:0] vc);
    mode = md; s1 = p1; s2 = p2; add_sel = ad; a = va; b = vb; c = vc;
    @(negedge clk);
  endtask

  initial begin
    #(5 * 100000);
    nfail++;
    $display("FAIL watchdog: got no finish, expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [TW+1:0] r;
    logic [TW-1:0] acc;
    rst = 1'b1; en = 1'b0;
    drive(2'b00, 1'b1, 1'b1, 1'b0, 4'hF, 4'hF, 4'h0);
    check("R1 reset", '0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0; en = 1'b1;

    // R3 R4 R5 R6 R9 R10 R11: full sweep, both ALU mode encodings
    for (int md = 0; md < 4; md += 3) begin
      for (int op = 0; op < 4; op++) begin
        for (int x = 0; x < FULL; x++) begin
          for (int y = 0; y < FULL; y++) begin
            drive(md[1:0], op[1], op[0], 1'b0, x[TW-1:0], y[TW-1:0], 4'h5);
            if (op[1]) begin
              r = ref_arith(x, y, !op[0]);
              check(md == 3 ? "R11 arith" : "R3 R5 R6 arith", r[TW-1:0], r[TW], r[TW+1],
                    x == y, x == 0);
            end else begin
              check(md == 3 ? "R11 logic" : "R4 logic",
                    op[0] ? (x[TW-1:0] & y[TW-1:0]) : (x[TW-1:0] ^ y[TW-1:0]),
                    1'b0, 1'b0, x == y, x == 0);
            end
          end
        end
      end
    end

    // R7: add-or-pass
    for (int ad = 0; ad < 2; ad++) begin
      for (int x = 0; x < FULL; x++) begin
        for (int y = 0; y < FULL; y++) begin
          drive(2'b01, 1'b0, 1'b0, ad[0], x[TW-1:0], y[TW-1:0], ~(x[TW-1:0] ^ y[TW-1:0]));
          r = ref_arith(x, y, 1'b0);
          if (ad == 1) check("R7 add", r[TW-1:0], r[TW], r[TW+1], x == y, x == 0);
          else check("R7 pass", ~(x[TW-1:0] ^ y[TW-1:0]), 1'b0, 1'b0, x == y, x == 0);
        end
      end
    end

    // R8: accumulate chains from every load value
    for (int ld = 0; ld < FULL; ld++) begin
      drive(2'b10, 1'b0, 1'b0, 1'b0, 4'h0, ld[TW-1:0], 4'h0);
      check("R8 load", ld[TW-1:0], 1'b0, 1'b0, ld == 0, 1'b1);
      acc = ld[TW-1:0];
      for (int k = 0; k < FULL; k++) begin
        int av = (k * 5 + ld) % FULL;
        drive(2'b10, 1'b1, 1'b1, 1'b1, av[TW-1:0], 4'h3, 4'h0);
        r = ref_arith(acc, av, 1'b0);
        check("R8 accumulate", r[TW-1:0], r[TW], r[TW+1], av == 3, av == 0);
        acc = r[TW-1:0];
      end
    end

    // R2: hold with enable low
    drive(2'b00, 1'b1, 1'b1, 1'b0, 4'h7, 4'h1, 4'h0);
    check("R2 setup", 4'h8, 1'b0, 1'b1, 1'b0, 1'b0);
    en = 1'b0;
    drive(2'b01, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 4'hA);
    check("R2 hold", 4'h8, 1'b0, 1'b1, 1'b0, 1'b0);
    drive(2'b10, 1'b0, 1'b0, 1'b0, 4'h0, 4'h0, 4'h0);
    check("R2 hold", 4'h8, 1'b0, 1'b1, 1'b0, 1'b0);

    // R1: reset wins over enable low
    rst = 1'b1;
    drive(2'b00, 1'b1, 1'b1, 1'b0, 4'h0, 4'h0, 4'h0);
    check("R1 reset with en low", '0, 1'b0, 1'b0, 1'b0, 1'b0);
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule